// File: doc/BRIEF.md
# Dual-Lane 16-bit Multiply-Accumulate Unit

This unit is a custom functional unit that runs two independent multiply-accumulate lanes side by side. Every accepted issue delivers two 32-bit source words. The lower 16-bit halves of the two words are multiplied and the product is added into the first accumulator. The upper halves are multiplied and the product is added into the second accumulator. Both accumulators are 40-bit state registers that are held apart from any general register file.

The datapath has two stages. Stage 1 registers the source words. Stage 2 reads both accumulators, adds the sign-extended products and writes the sums back in the same cycle. Because the read and the write sit in one stage, issues on consecutive cycles chain onto each other without a stall or a forwarding path.

A plain access port lets software inspect and load the state. The read side is combinational and returns either the 32-bit low word or the 8 top bits of a selected accumulator. The write side loads one of those two parts on a clock edge.

Issue uses a valid/ready handshake. The unit applies no back-pressure: `issue_ready` is high whenever reset is released, so an issue is accepted on every edge at which `issue_valid` is high.

Top module: `dual_mac16`

## Requirements
- R1: While `rst_n` is low, both accumulators are cleared to zero and `issue_ready` is low.
- R2: An accepted issue adds the signed product of `src_a[15:0]` and `src_b[15:0]` into accumulator 0.
- R3: An accepted issue adds the signed product of `src_a[31:16]` and `src_b[31:16]` into accumulator 1.
- R4: Each 32-bit product is sign-extended to 40 bits before the add, and the sum wraps modulo 2^40.
- R5: An issue accepted at clock edge N changes the accumulators at edge N+1. Between those two edges the read port still shows the old value.
- R6: `issue_ready` stays high while reset is released. Issues on every cycle all accumulate with no lost or repeated update.
- R7: The read port is combinational. `rd_sel` picks the accumulator (0 = low-half lane, 1 = high-half lane). With `rd_hi` = 0 it returns bits [31:0]. With `rd_hi` = 1 it returns bits [39:32] in `rd_data[7:0]`, and `rd_data[31:8]` is zero.
- R8: With `wr_en` high, `wr_hi` = 0 loads `wr_data` into bits [31:0] of the accumulator picked by `wr_sel`. With `wr_hi` = 1 it loads `wr_data[7:0]` into bits [39:32]. The other part of that accumulator does not change. The new value is visible after the next edge.
- R9: If a write arrives in a cycle in which a MAC update is in stage 2, the MAC update is applied and the write is dropped.
- R10: When `issue_valid` is low, the source words have no effect on the accumulators.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | A MAC issue is offered |
| issue_ready | output | 1 | The unit accepts the issue (high outside reset) |
| src_a | input | 32 | First source word; two 16-bit signed halves |
| src_b | input | 32 | Second source word; two 16-bit signed halves |
| wr_en | input | 1 | Accumulator part write strobe |
| wr_sel | input | 1 | Accumulator picked for the write |
| wr_hi | input | 1 | 0 = write bits [31:0], 1 = write bits [39:32] |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Accumulator picked for the read |
| rd_hi | input | 1 | 0 = read bits [31:0], 1 = read bits [39:32] zero-extended |
| rd_data | output | 32 | Read data |

## Verification
An issue that is accepted at one edge shows in `rd_data` only after the next edge, so a MAC result is due two edges after the inputs are driven. A part write is due one edge after it is driven, and a read is due in the same cycle as its select. The bench drives inputs on the falling edge. It keeps a reference model with a one-entry stage-2 slot that is updated on the rising edge. On every falling edge it compares the selected read view with the model, so each result is checked in exactly the cycle it becomes due. Directed sequences cover latency, back-to-back issue, wrap-around, collision of a write with a MAC update, and part writes. A long random phase then mixes all of these.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int unsigned DEF_HALF_W = 16;
  localparam int unsigned DEF_LANES  = 2;
  localparam int unsigned DEF_ACC_W  = 40;
  localparam int unsigned DEF_WORD_W = 32;

  // which part of an accumulator the access port addresses
  typedef enum logic {
    ACC_PART_LO = 1'b0,
    ACC_PART_HI = 1'b1
  } acc_part_e;
endpackage

// File: rtl/dmac_issue_stage.sv
// Stage 1: captures the source words of an accepted issue.
module dmac_issue_stage #(
  parameter int unsigned SRC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [SRC_W-1:0] in_a,
  input  logic [SRC_W-1:0] in_b,
  output logic             s2_valid,
  output logic [SRC_W-1:0] s2_a,
  output logic [SRC_W-1:0] s2_b
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_a     <= '0;
      s2_b     <= '0;
    end else begin
      s2_valid <= accept;
      if (accept) begin
        s2_a <= in_a;
        s2_b <= in_b;
      end
    end
  end

  // R5: an accepted issue occupies stage 2 in the following cycle
  a_r5_stage_follows: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> s2_valid);
  // R10: no issue, no stage-2 work
  a_r10_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !s2_valid);
endmodule

// File: rtl/dmac_lane.sv
// Stage 2 of one lane: signed product, sign extension and accumulator state.
module dmac_lane
  import dmac_pkg::*;
#(
  parameter int unsigned HALF_W = 16,
  parameter int unsigned ACC_W  = 40,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mac_en,
  input  logic [HALF_W-1:0] op_a,
  input  logic [HALF_W-1:0] op_b,
  input  logic              wr_en,
  input  acc_part_e         wr_part,
  input  logic [WORD_W-1:0] wr_data,
  output logic [ACC_W-1:0]  acc
);
  localparam int unsigned PROD_W = 2 * HALF_W;
  localparam int unsigned HI_W   = ACC_W - WORD_W;
  localparam int unsigned EXT_W  = ACC_W - PROD_W;

  logic signed [PROD_W-1:0] prod;
  logic        [ACC_W-1:0]  prod_ext;
  logic        [ACC_W-1:0]  acc_nxt;

  always_comb begin
    prod     = $signed(op_a) * $signed(op_b);
    prod_ext = {{EXT_W{prod[PROD_W-1]}}, prod};
  end

  // the MAC update outranks a software write in the same cycle
  always_comb begin
    acc_nxt = acc;
    if (mac_en) begin
      acc_nxt = acc + prod_ext;
    end else if (wr_en) begin
      if (wr_part == ACC_PART_HI) acc_nxt[ACC_W-1:WORD_W] = wr_data[HI_W-1:0];
      else                        acc_nxt[WORD_W-1:0]     = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else        acc <= acc_nxt;
  end

  // R10: with neither a MAC update nor a write, the state holds
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mac_en && !wr_en) |=> $stable(acc));
  // R8: a high-part write leaves the low word alone
  a_r8_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (!mac_en && wr_en && wr_part == ACC_PART_HI)
      |=> acc[WORD_W-1:0] == $past(acc[WORD_W-1:0]));
  // R9: a zero-product MAC colliding with a write leaves the state unchanged
  a_r9_mac_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_en && wr_en && op_a == '0) |=> $stable(acc));
endmodule

// File: rtl/dual_mac16.sv
module dual_mac16
  import dmac_pkg::*;
#(
  parameter int unsigned HALF_W = DEF_HALF_W,
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned ACC_W  = DEF_ACC_W,
  parameter int unsigned WORD_W = DEF_WORD_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            issue_valid,
  output logic                            issue_ready,
  input  logic [LANES*HALF_W-1:0]         src_a,
  input  logic [LANES*HALF_W-1:0]         src_b,
  input  logic                            wr_en,
  input  logic [$clog2(LANES)-1:0]        wr_sel,
  input  logic                            wr_hi,
  input  logic [WORD_W-1:0]               wr_data,
  input  logic [$clog2(LANES)-1:0]        rd_sel,
  input  logic                            rd_hi,
  output logic [WORD_W-1:0]               rd_data
);
  localparam int unsigned SRC_W = LANES * HALF_W;
  localparam int unsigned SEL_W = $clog2(LANES);
  localparam int unsigned HI_W  = ACC_W - WORD_W;
  localparam int unsigned PAD_W = WORD_W - HI_W;

  logic             accept;
  logic             s2_valid;
  logic [SRC_W-1:0] s2_a;
  logic [SRC_W-1:0] s2_b;
  logic [ACC_W-1:0] acc_q [LANES];

  // no back-pressure: ready only drops during reset
  assign issue_ready = rst_n;
  assign accept      = issue_valid & issue_ready;

  dmac_issue_stage #(.SRC_W(SRC_W)) u_issue (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .in_a     (src_a),
    .in_b     (src_b),
    .s2_valid (s2_valid),
    .s2_a     (s2_a),
    .s2_b     (s2_b)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic lane_wr;
    assign lane_wr = wr_en && (wr_sel == SEL_W'(g));

    dmac_lane #(
      .HALF_W (HALF_W),
      .ACC_W  (ACC_W),
      .WORD_W (WORD_W)
    ) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .mac_en  (s2_valid),
      .op_a    (s2_a[g*HALF_W +: HALF_W]),
      .op_b    (s2_b[g*HALF_W +: HALF_W]),
      .wr_en   (lane_wr),
      .wr_part (acc_part_e'(wr_hi)),
      .wr_data (wr_data),
      .acc     (acc_q[g])
    );
  end

  always_comb begin
    if (rd_hi) rd_data = {{PAD_W{1'b0}}, acc_q[rd_sel][ACC_W-1:WORD_W]};
    else       rd_data = acc_q[rd_sel][WORD_W-1:0];
  end

  // R7: the high view is zero-extended
  a_r7_hi_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |-> rd_data[WORD_W-1:HI_W] == '0);
  // R6: outside reset an offered issue is always taken
  a_r6_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> accept);
endmodule

// File: tb/dual_mac16_tb.sv
`timescale 1ns/1ps
module dual_mac16_tb_top;
  localparam int CYC_NS   = 4;
  localparam int WDOG_CYC = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic        issue_ready;
  logic [31:0] src_a = '0, src_b = '0;
  logic        wr_en = 1'b0;
  logic [0:0]  wr_sel = '0;
  logic        wr_hi = 1'b0;
  logic [31:0] wr_data = '0;
  logic [0:0]  rd_sel = '0;
  logic        rd_hi = 1'b0;
  logic [31:0] rd_data;

  int    n_chk = 0, n_fail = 0;
  bit    finished = 0;
  string last_req = "R1";

  always #(CYC_NS/2) clk = ~clk;

  dual_mac16 dut_i (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
    .src_a(src_a), .src_b(src_b), .wr_en(wr_en), .wr_sel(wr_sel), .wr_hi(wr_hi),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_hi(rd_hi), .rd_data(rd_data)
  );

  // ---------------- reference model (behavioural, per clock) --------------
  logic [39:0] m_acc [2];
  bit          m_pend = 0;
  logic [31:0] m_a = '0, m_b = '0;

  function automatic longint lane_prod(logic [31:0] a, logic [31:0] b, int lane);
    shortint sa, sb;
    sa = shortint'(lane == 0 ? a[15:0] : a[31:16]);
    sb = shortint'(lane == 0 ? b[15:0] : b[31:16]);
    return longint'(sa) * longint'(sb);
  endfunction

  initial begin
    m_acc[0] = '0;
    m_acc[1] = '0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc[0] = '0;
      m_acc[1] = '0;
      m_pend   = 0;
    end else begin
      if (m_pend) begin
        for (int l = 0; l < 2; l++)
          m_acc[l] = m_acc[l] + 40'(lane_prod(m_a, m_b, l));
      end else if (wr_en) begin
        if (wr_hi) m_acc[wr_sel][39:32] = wr_data[7:0];
        else       m_acc[wr_sel][31:0]  = wr_data;
      end
      m_pend = issue_valid;
      if (issue_valid) begin
        m_a = src_a;
        m_b = src_b;
      end
    end
  end

  function automatic logic [31:0] model_view(int s, bit h);
    return h ? {24'h0, m_acc[s][39:32]} : m_acc[s][31:0];
  endfunction

  // ---------------- checking and driving ----------------------------------
  task automatic check_read();
    logic [31:0] exp;
    exp = model_view(int'(rd_sel), rd_hi);
    n_chk++;
    if (rd_data !== exp) begin
      n_fail++;
      $display("FAIL %s: acc%0d %s view got %h expected %h", last_req,
               rd_sel, rd_hi ? "hi" : "lo", rd_data, exp);
    end
  endtask

  task automatic step(string req, bit v, logic [31:0] a, logic [31:0] b,
                      bit we, bit ws, bit wh, logic [31:0] wd, bit rs, bit rh);
    @(negedge clk);
    check_read();
    last_req    = req;
    issue_valid = v;
    src_a = a; src_b = b;
    wr_en = we; wr_sel = ws; wr_hi = wh; wr_data = wd;
    rd_sel = rs; rd_hi = rh;
  endtask

  task automatic idle_read(string req, bit rs, bit rh);
    step(req, 0, 32'hDEAD_BEEF, 32'h1234_5678, 0, 0, 0, '0, rs, rh);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(WDOG_CYC * CYC_NS);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: ready low in reset
    n_chk++;
    if (issue_ready !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: issue_ready in reset got %b expected 0", issue_ready);
    end
    rst_n = 1'b1;
    // R1: all four views read zero after reset
    idle_read("R1", 0, 0);
    idle_read("R1", 0, 1);
    idle_read("R1", 1, 0);
    idle_read("R1", 1, 1);
    // R6: ready high once reset is released
    n_chk++;
    if (issue_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R6: issue_ready got %b expected 1", issue_ready);
    end

    // R2/R3/R4: lo lane -3*4 = -12, hi lane 2*7 = 14
    step("R2", 1, 32'h0002_FFFD, 32'h0007_0004, 0, 0, 0, '0, 0, 0);
    idle_read("R5", 0, 0);      // one edge: not yet updated
    idle_read("R2", 0, 0);      // two edges: -12 low word
    idle_read("R4", 0, 1);      // sign extension: hi = FF
    idle_read("R3", 1, 0);
    idle_read("R7", 1, 1);

    // R8: part writes
    step("R8", 0, '0, '0, 1, 0, 0, 32'hFFFF_FFFF, 0, 0);
    step("R8", 0, '0, '0, 1, 0, 1, 32'hFFFF_FF7F, 0, 0);
    idle_read("R8", 0, 0);
    idle_read("R7", 0, 1);
    step("R8", 0, '0, '0, 1, 0, 1, 32'h0000_00FF, 0, 1);
    idle_read("R8", 0, 1);
    idle_read("R8", 0, 0);

    // R4: wrap 0xFF_FFFF_FFFF + 1 -> 0
    step("R4", 1, 32'h0000_0001, 32'h0000_0001, 0, 0, 0, '0, 0, 0);
    idle_read("R4", 0, 0);
    idle_read("R4", 0, 1);
    idle_read("R4", 0, 0);

    // R9: write collides with stage-2 MAC on both lanes
    step("R9", 1, 32'h0100_0010, 32'h0100_0010, 0, 0, 0, '0, 1, 0);
    step("R9", 0, '0, '0, 1, 1, 0, 32'hAAAA_5555, 1, 0);
    idle_read("R9", 1, 0);
    idle_read("R9", 1, 1);
    idle_read("R9", 0, 0);

    // R10: source words change with valid low
    for (int i = 0; i < 6; i++)
      step("R10", 0, 32'h7FFF_8000 ^ i, 32'h8000_7FFF + i, 0, 0, 0, '0, i[0], i[1]);
    idle_read("R10", 0, 0);

    // R6: back-to-back issues at full rate, extreme operands
    for (int i = 0; i < 30; i++)
      step("R6", 1, (i % 3 == 0) ? 32'h8000_8000 : 32'h7FFF_0003 + i,
           32'h8000_FFFF - i, 0, 0, 0, '0, i[0], i[1]);
    for (int i = 0; i < 4; i++) idle_read("R6", i[0], i[1]);

    // random mix of issues, writes and reads
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step((r < 20) ? "R9" : "R6", r < 60, $urandom, $urandom,
           ($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom), $urandom,
           1'($urandom), 1'($urandom));
    end
    for (int i = 0; i < 4; i++) idle_read("R7", i[0], i[1]);

    finished = 1;
    summary();
    $finish;
  end
endmodule